// File: doc/BRIEF.md
# Condition Flag Gather and Replication Network

This block produces the 16-bit condition input for a downstream threshold unit. Its source is a condition file of four 32-bit words. In each word, bits 15:0 hold per-byte sign flags and bits 31:16 hold per-byte zero flags. A paired scalar instruction can send a small control field. That field picks one word, picks the sign or the zero half of it, and picks one of eight fixed gather patterns. The patterns copy selected flag bits into neighbouring positions, in the manner used to derive neighbour availability for blocks in video coding.

One pattern draws from two words. Its low byte comes from the selected word, and its high byte comes from the word whose index is the selected index with bit 0 forced to one. When no scalar instruction is paired, the field reads as all zeros. The block then passes the sign half of word 0 through unchanged. The result is registered, so it appears one clock after its inputs.

Top module: `cflag_gather`

## Requirements
- R1: While reset is asserted, and on the first clock after it, `flags_out` is zero.
- R2: With `pair_vld` low, the scalar bits are ignored and `flags_out` equals bits 15:0 of word 0.
- R3: With `pair_vld` high, `sop_hi[20:19]` chooses the word. Word n occupies `cond_file[32n+31:32n]`.
- R4: With `pair_vld` high and `sop_hi[21]` set, the zero half (bits 31:16) of the chosen word is used. When `sop_hi[21]` is clear, the sign half (bits 15:0) is used.
- R5: The pattern number is `sop_hi[22]` + 2·`sop_hi[23]` + 4·`sop_b0`. Pattern 0 passes the 16 half bits through unchanged.
- R6: Pattern 1 maps each output quad k (bits 4k..4k+3) to input bit 4k+2. Pattern 6 maps each output quad k to input bit 4k+1.
- R7: Pattern 2 maps output bits 0..7 to input bits 4,5,4,5,4,5,4,5 and output bits 8..15 to input bits 12,13,12,13,12,13,12,13.
- R8: Pattern 3 maps the output bits of quad k, in order, to input bits 4k, 4k, 4k+2, 4k. Pattern 4 maps them to 4k+1, 4k+1, 4k+1, 4k+3.
- R9: Pattern 5 maps output bit o to input bit o with bit 0 cleared.
- R10: For pattern 7, output bit o (o<8) is bit 2o of the chosen half. Output bit 8+o is bit 2o of the same half of word (index | 1).
- R11: Every cycle, `flags_out` reflects the inputs sampled at the previous rising edge, with exactly one cycle of latency.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| pair_vld | input | 1 | A scalar instruction is paired this cycle |
| sop_hi | input | 5 | Scalar opcode bits 23:19 |
| sop_b0 | input | 1 | Scalar opcode bit 0 |
| cond_file | input | 128 | Four condition words, word n at bits 32n+31:32n |
| flags_out | output | 16 | Gathered condition word |

## Verification
Every result is due exactly one clock after the inputs that produce it, because the only register on the path is the output register. The bench drives each vector on a falling edge. It records the expected word in a queue, then compares it on the next falling edge, which is half a cycle after the capturing rising edge. The bench pops that entry before it drives the next vector. The reset value is checked while reset is held, before any vector enters the queue.

// File: rtl/cflag_pkg.sv
package cflag_pkg;
  localparam int NUM_WORDS = 4;
  localparam int WORD_W    = 32;
  localparam int HALF_W    = WORD_W / 2;
  localparam int IDX_W     = $clog2(NUM_WORDS);
  localparam int PAT_W     = 3;
  localparam int NUM_PAT   = 1 << PAT_W;
  localparam int BYTE_HALF = HALF_W / 2;

  typedef struct packed {
    logic [IDX_W-1:0] word;
    logic             zero_half;
    logic [PAT_W-1:0] pat;
  } cf_sel_t;

  // Source bit in the primary half for output bit o under pattern p.
  // Pattern 7 upper byte is served from the secondary word elsewhere.
  function automatic int src_pos(input int p, input int o);
    int q;
    int i;
    q = o & ~3;
    i = o & 3;
    case (p)
      0: src_pos = o;
      1: src_pos = q | 2;
      2: src_pos = (o & 8) | 4 | (o & 1);
      3: src_pos = (i == 2) ? q + 2 : q;
      4: src_pos = (i == 3) ? q + 3 : q + 1;
      5: src_pos = o & ~1;
      6: src_pos = q | 1;
      default: src_pos = (o < BYTE_HALF) ? 2 * o : 2 * (o - BYTE_HALF);
    endcase
  endfunction
endpackage

// File: rtl/cflag_decode.sv
module cflag_decode
  import cflag_pkg::*;
(
  input  logic        pair_vld,
  input  logic [23:19] sop_hi,
  input  logic        sop_b0,
  output cf_sel_t     sel
);
  always_comb begin
    sel = '0;
    if (pair_vld) begin
      sel.word      = sop_hi[20:19];
      sel.zero_half = sop_hi[21];
      sel.pat       = {sop_b0, sop_hi[23], sop_hi[22]};
    end
  end
endmodule

// File: rtl/cflag_pick.sv
module cflag_pick
  import cflag_pkg::*;
(
  input  logic [NUM_WORDS*WORD_W-1:0] cond_file,
  input  cf_sel_t                     sel,
  output logic [HALF_W-1:0]           pri_half,
  output logic [BYTE_HALF-1:0]        sec_even
);
  logic [IDX_W-1:0]  sec_idx;
  logic [HALF_W-1:0] sec_half;

  always_comb begin
    sec_idx  = sel.word | IDX_W'(1);
    pri_half = cond_file[sel.word * WORD_W + (sel.zero_half ? HALF_W : 0) +: HALF_W];
    sec_half = cond_file[sec_idx * WORD_W + (sel.zero_half ? HALF_W : 0) +: HALF_W];
  end

  for (genvar e = 0; e < BYTE_HALF; e++) begin : g_even
    assign sec_even[e] = sec_half[2*e];
  end
endmodule

// File: rtl/cflag_net.sv
module cflag_net
  import cflag_pkg::*;
(
  input  logic [PAT_W-1:0]     pat,
  input  logic [HALF_W-1:0]    pri_half,
  input  logic [BYTE_HALF-1:0] sec_even,
  output logic [HALF_W-1:0]    gathered
);
  logic [HALF_W-1:0][NUM_PAT-1:0] cand;

  for (genvar o = 0; o < HALF_W; o++) begin : g_bit
    for (genvar p = 0; p < NUM_PAT; p++) begin : g_pat
      if (p == NUM_PAT - 1 && o >= BYTE_HALF) begin : g_second
        assign cand[o][p] = sec_even[o - BYTE_HALF];
      end else begin : g_first
        localparam int S = src_pos(p, o);
        assign cand[o][p] = pri_half[S];
      end
    end
    assign gathered[o] = cand[o][pat];
  end
endmodule

// File: rtl/cflag_gather.sv
module cflag_gather
  import cflag_pkg::*;
(
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        pair_vld,
  input  logic [23:19]                sop_hi,
  input  logic                        sop_b0,
  input  logic [NUM_WORDS*WORD_W-1:0] cond_file,
  output logic [HALF_W-1:0]           flags_out
);
  cf_sel_t               sel;
  logic [HALF_W-1:0]     pick_pri;
  logic [BYTE_HALF-1:0]  pick_sec;
  logic [HALF_W-1:0]     net_out;
  logic                  primed;

  cflag_decode u_dec (
    .pair_vld (pair_vld),
    .sop_hi   (sop_hi),
    .sop_b0   (sop_b0),
    .sel      (sel)
  );

  cflag_pick u_pick (
    .cond_file (cond_file),
    .sel       (sel),
    .pri_half  (pick_pri),
    .sec_even  (pick_sec)
  );

  cflag_net u_net (
    .pat      (sel.pat),
    .pri_half (pick_pri),
    .sec_even (pick_sec),
    .gathered (net_out)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flags_out <= '0;
      primed    <= 1'b0;
    end else begin
      flags_out <= net_out;
      primed    <= 1'b1;
    end
  end

  // Assertions
  AST_RESET_CLEAR: assert property (@(posedge clk)
    !rst_n |=> flags_out == '0); // R1

  AST_DEFAULT_WORD0: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(!pair_vld)) |-> flags_out == $past(cond_file[HALF_W-1:0])); // R2

  AST_PASS_THROUGH: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(pair_vld && sop_hi[23:22] == 2'b00 && !sop_b0))
      |-> flags_out == $past(pick_pri)); // R5

  AST_QUAD_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(pair_vld && sop_hi[23:22] == 2'b01 && !sop_b0))
      |-> (flags_out == {{4{flags_out[12]}}, {4{flags_out[8]}},
                         {4{flags_out[4]}},  {4{flags_out[0]}}})); // R6

  AST_PAIR_TIE: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(pair_vld && sop_hi[23:22] == 2'b01 && sop_b0))
      |-> ((flags_out & 16'hAAAA) == ((flags_out & 16'h5555) << 1))); // R9

  AST_SECOND_WORD: assert property (@(posedge clk) disable iff (!rst_n)
    (primed && $past(pair_vld && sop_hi[23:22] == 2'b11 && sop_b0 && sop_hi[19]))
      |-> flags_out[15:8] == flags_out[7:0]); // R10

  AST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    primed && $stable(net_out) |=> flags_out == $past(net_out)); // R11
endmodule

// File: tb/tb_cflag_gather.sv
`timescale 1ns/1ps
module tb_cflag_gather;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         pair_vld = 1'b0;
  logic [23:19] sop_hi = '0;
  logic         sop_b0 = 1'b0;
  logic [127:0] cond_file = '0;
  logic [15:0]  flags_out;

  int vectors = 0;
  int misses = 0;
  bit done = 0;
  logic [15:0] exp_q[$];
  string       tag_q[$];

  always #2 clk = ~clk;

  cflag_gather dut (
    .clk(clk), .rst_n(rst_n), .pair_vld(pair_vld),
    .sop_hi(sop_hi), .sop_b0(sop_b0),
    .cond_file(cond_file), .flags_out(flags_out)
  );

  localparam int P1[16] = '{2,2,2,2,6,6,6,6,10,10,10,10,14,14,14,14};
  localparam int P2[16] = '{4,5,4,5,4,5,4,5,12,13,12,13,12,13,12,13};
  localparam int P3[16] = '{0,0,2,0,4,4,6,4,8,8,10,8,12,12,14,12};
  localparam int P4[16] = '{1,1,1,3,5,5,5,7,9,9,9,11,13,13,13,15};
  localparam int P5[16] = '{0,0,2,2,4,4,6,6,8,8,10,10,12,12,14,14};
  localparam int P6[16] = '{1,1,1,1,5,5,5,5,9,9,9,9,13,13,13,13};

  function automatic logic [15:0] half_of(logic [127:0] f, int w, int h);
    return f[w*32 + h*16 +: 16];
  endfunction

  function automatic logic [15:0] model(logic pv, logic [23:19] hi, logic b0,
                                        logic [127:0] f);
    int w, h, p, src;
    logic [15:0] a, b, r;
    if (!pv) return f[15:0];
    w = int'(hi[20:19]);
    h = int'(hi[21]);
    p = int'(hi[22]) + 2*int'(hi[23]) + 4*int'(b0);
    a = half_of(f, w, h);
    b = half_of(f, w | 1, h);
    r = '0;
    for (int o = 0; o < 16; o++) begin
      case (p)
        0: src = o;
        1: src = P1[o];
        2: src = P2[o];
        3: src = P3[o];
        4: src = P4[o];
        5: src = P5[o];
        6: src = P6[o];
        default: src = 0;
      endcase
      if (p == 7) r[o] = (o < 8) ? a[2*o] : b[2*(o-8)];
      else        r[o] = a[src];
    end
    return r;
  endfunction

  function automatic string req_of(logic pv, logic [23:19] hi, logic b0);
    int p;
    if (!pv) return "R2";
    p = int'(hi[22]) + 2*int'(hi[23]) + 4*int'(b0);
    case (p)
      0: return "R5 R3 R4";
      1, 6: return "R6 R3 R4";
      2: return "R7 R3 R4";
      3, 4: return "R8 R3 R4";
      5: return "R9 R3 R4";
      default: return "R10 R3 R4";
    endcase
  endfunction

  task automatic compare_due();
    logic [15:0] e;
    string t;
    if (exp_q.size() != 0) begin
      e = exp_q.pop_front();
      t = tag_q.pop_front();
      vectors++;
      if (flags_out !== e) begin
        misses++;
        $display("FAIL %s R11: flags_out=%h expected=%h", t, flags_out, e);
      end
    end
  endtask

  task automatic apply(logic pv, logic [23:19] hi, logic b0, logic [127:0] f);
    @(negedge clk);
    compare_due();
    pair_vld  = pv;
    sop_hi    = hi;
    sop_b0    = b0;
    cond_file = f;
    exp_q.push_back(model(pv, hi, b0, f));
    tag_q.push_back(req_of(pv, hi, b0));
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", vectors, misses);
      $finish;
    end
  endtask

  initial begin
    #100000;
    misses++;
    $display("FAIL watchdog: run hung, actual=timeout expected=completion");
    finish_run();
  end

  initial begin
    cond_file = {$urandom, $urandom, $urandom, $urandom};
    repeat (3) @(negedge clk);
    vectors++;
    if (flags_out !== 16'h0) begin
      misses++;
      $display("FAIL R1: flags_out=%h expected=0000", flags_out);
    end
    rst_n = 1'b1;

    // R2: unpaired, scalar bits must be ignored
    for (int k = 0; k < 8; k++)
      apply(1'b0, 5'($urandom), 1'($urandom),
            {$urandom, $urandom, $urandom, $urandom});

    // Full sweep of word, half and pattern
    for (int s = 0; s < 64; s++) begin
      logic [127:0] f;
      f = {$urandom, $urandom, $urandom, $urandom};
      apply(1'b1, 5'(s & 31), 1'(s >> 5), f);
    end

    // One-hot condition words expose each source bit mapping
    for (int bitn = 0; bitn < 128; bitn += 3)
      for (int s = 0; s < 64; s += 5)
        apply(1'b1, 5'(s & 31), 1'(s >> 5), 128'(1) << bitn);

    // Random mix, including back-to-back changes
    for (int k = 0; k < 400; k++)
      apply(1'($urandom), 5'($urandom), 1'($urandom),
            {$urandom, $urandom, $urandom, $urandom});

    apply(1'b0, '0, 1'b0, '0);
    @(negedge clk);
    compare_due();
    finish_run();
  end
endmodule